// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer with Write Permission

This block caches recent virtual-to-physical page translations for a processor using 4 KB pages. Each cycle it may accept one lookup, carrying a virtual address and a read/write flag, and one cycle later it reports one of three outcomes:
- a physical address;
- a translation miss;
- a write-permission fault.

The low 12 address bits are the page offset and are never translated. The virtual and physical page numbers have different widths: 20 bits and 18 bits by default.

Storage holds 64 translations in 16 sets of 4 ways. Bits [15:12] of the virtual address select the set, and the remaining upper bits form the tag that is compared. Each stored translation keeps a valid flag, its tag, the physical page number and a write-permit flag.

After a miss, an external walker installs a translation through the fill port. Within a set, space is reclaimed in true least-recently-used order. A flush input invalidates everything in one cycle.

Top module: `page_xlat_tlb`

## Requirements
- R1: A lookup whose page number has a valid stored translation, and which is not a write-permission fault, returns `rsp_paddr_o = {stored physical page number, req_vaddr_i[11:0]}`. The set is `req_vaddr_i[15:12]` and the tag is `req_vaddr_i[31:16]`.
- R2: `rsp_valid_o` is high on exactly the cycle after each cycle in which `req_valid_i` is high. When `rsp_valid_o` is low, `rsp_miss_o`, `rsp_wprot_o` and `rsp_paddr_o` are all zero.
- R3: A lookup with no valid matching translation gives `rsp_miss_o=1`, `rsp_wprot_o=0` and `rsp_paddr_o=0`.
- R4: A write lookup that hits a translation whose write-permit flag is clear gives `rsp_wprot_o=1`, `rsp_miss_o=0` and `rsp_paddr_o=0`. A read lookup of the same translation translates normally.
- R5: A fill changes contents from the next cycle. A lookup in the same cycle as the fill sees the earlier contents.
- R6: Filling a page number that is already held overwrites that translation's physical page and write permit in place. No second copy is created.
- R7: Each set holds 4 distinct translations, for 64 in total. A fill into a set with a free way takes the free way. A fill into a full set replaces the least recently used translation.
- R8: A lookup hit makes that translation the most recently used in its set. This includes a hit that raises a write-permission fault. A fill makes the written translation the most recently used.
- R9: `flush_i` invalidates every translation at the next edge. A fill presented in the same cycle is discarded. A lookup in the same cycle sees the earlier contents.
- R10: After reset no translation is valid and `rsp_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request this cycle |
| req_write_i | input | 1 | Lookup is a write access |
| req_vaddr_i | input | 32 | Virtual address to translate |
| fill_valid_i | input | 1 | Install a translation this cycle |
| fill_vpn_i | input | 20 | Virtual page number to install |
| fill_ppn_i | input | 18 | Physical page number to install |
| fill_wr_ok_i | input | 1 | Write-permit flag to install |
| flush_i | input | 1 | Invalidate every translation |
| rsp_valid_o | output | 1 | Lookup result valid (one cycle after request) |
| rsp_miss_o | output | 1 | Translation miss |
| rsp_wprot_o | output | 1 | Write-permission fault |
| rsp_paddr_o | output | 30 | Translated physical address, zero on miss or fault |

## Verification
A corrupted recency order stays hidden at the ports until its set is full and one more fill arrives. It then shows as a miss, on the next lookup, for a page that should have survived. The bench therefore fills sets to capacity, touches chosen ways with both plain hits and write-fault hits, and probes every survivor after the eviction.

A wrong valid, tag or permit bit shows up one cycle after the first lookup of that page: a false miss, a wrong physical page, or a missing or spurious write fault. The same-cycle fill, lookup and flush cases pin down the point at which new contents become visible. A long pseudo-random mix over two sets compares every response with an independent recency-ordered model.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int PAGE_OFS_W = 12;

  typedef enum logic [1:0] {
    XLAT_OK    = 2'd0,
    XLAT_MISS  = 2'd1,
    XLAT_WPROT = 2'd2
  } xlat_res_e;
endpackage

// File: rtl/tlb_way_match.sv
module tlb_way_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 16,
  parameter int PPN_W = 18,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [TAG_W-1:0]            tag_i,
  input  logic [WAYS-1:0]             val_i,
  input  logic [WAYS-1:0][TAG_W-1:0]  tags_i,
  input  logic [WAYS-1:0][PPN_W-1:0]  ppns_i,
  input  logic [WAYS-1:0]             woks_i,
  output logic                        hit_o,
  output logic [WAY_W-1:0]            way_o,
  output logic [PPN_W-1:0]            ppn_o,
  output logic                        wok_o
);
  logic [WAYS-1:0] hit_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = val_i[w] && (tags_i[w] == tag_i);
  end

  always_comb begin
    hit_o = |hit_vec;
    way_o = '0;
    ppn_o = '0;
    wok_o = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) begin
        way_o = WAY_W'(w);
        ppn_o = ppns_i[w];
        wok_o = woks_i[w];
      end
    end
  end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lk_touch_i,
  input  logic [IDX_W-1:0] lk_set_i,
  input  logic [WAY_W-1:0] lk_way_i,
  input  logic             fl_touch_i,
  input  logic [IDX_W-1:0] fl_set_i,
  input  logic [WAY_W-1:0] fl_way_i,
  output logic [WAY_W-1:0] victim_o
);
  // rank 0 = most recent, WAYS-1 = least recent
  typedef logic [WAYS-1:0][WAY_W-1:0] rank_t;

  rank_t rank_q [SETS];
  rank_t rank_d [SETS];
  rank_t fl_base;

  function automatic rank_t touch(rank_t r, logic [WAY_W-1:0] w);
    rank_t n = r;
    for (int i = 0; i < WAYS; i++)
      if (r[i] < r[w]) n[i] = r[i] + WAY_W'(1);
    n[w] = '0;
    return n;
  endfunction

  // victim sees the lookup touch of the same cycle
  always_comb begin
    fl_base = rank_q[fl_set_i];
    if (lk_touch_i && lk_set_i == fl_set_i) fl_base = touch(fl_base, lk_way_i);
    victim_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (fl_base[w] == WAY_W'(WAYS - 1)) victim_o = WAY_W'(w);
  end

  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      rank_d[s] = rank_q[s];
      if (lk_touch_i && lk_set_i == IDX_W'(s)) rank_d[s] = touch(rank_d[s], lk_way_i);
      if (fl_touch_i && fl_set_i == IDX_W'(s)) rank_d[s] = touch(rank_d[s], fl_way_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          rank_q[s][w] <= WAY_W'(w);
    end else begin
      for (int s = 0; s < SETS; s++) rank_q[s] <= rank_d[s];
    end
  end
endmodule

// File: rtl/page_xlat_tlb.sv
module page_xlat_tlb
  import tlb_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PA_W    = 30,
  parameter int ENTRIES = 64,
  parameter int WAYS    = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_valid_i,
  input  logic                       req_write_i,
  input  logic [VA_W-1:0]            req_vaddr_i,
  input  logic                       fill_valid_i,
  input  logic [VA_W-PAGE_OFS_W-1:0] fill_vpn_i,
  input  logic [PA_W-PAGE_OFS_W-1:0] fill_ppn_i,
  input  logic                       fill_wr_ok_i,
  input  logic                       flush_i,
  output logic                       rsp_valid_o,
  output logic                       rsp_miss_o,
  output logic                       rsp_wprot_o,
  output logic [PA_W-1:0]            rsp_paddr_o
);
  localparam int OFS_W = PAGE_OFS_W;
  localparam int SETS  = ENTRIES / WAYS;
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int VPN_W = VA_W - OFS_W;
  localparam int PPN_W = PA_W - OFS_W;
  localparam int TAG_W = VPN_W - IDX_W;

  logic [WAYS-1:0]             val_q [SETS];
  logic [WAYS-1:0][TAG_W-1:0]  tag_q [SETS];
  logic [WAYS-1:0][PPN_W-1:0]  ppn_q [SETS];
  logic [WAYS-1:0]             wok_q [SETS];

  // lookup side
  logic [IDX_W-1:0] lk_set;
  logic [TAG_W-1:0] lk_tag;
  logic             lk_hit, lk_wok;
  logic [WAY_W-1:0] lk_way;
  logic [PPN_W-1:0] lk_ppn;
  xlat_res_e        lk_res;

  assign lk_set = req_vaddr_i[OFS_W +: IDX_W];
  assign lk_tag = req_vaddr_i[VA_W-1 -: TAG_W];

  tlb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_lk_match (
    .tag_i (lk_tag),
    .val_i (val_q[lk_set]),
    .tags_i(tag_q[lk_set]),
    .ppns_i(ppn_q[lk_set]),
    .woks_i(wok_q[lk_set]),
    .hit_o (lk_hit),
    .way_o (lk_way),
    .ppn_o (lk_ppn),
    .wok_o (lk_wok)
  );

  always_comb begin
    if (!lk_hit)                      lk_res = XLAT_MISS;
    else if (req_write_i && !lk_wok)  lk_res = XLAT_WPROT;
    else                              lk_res = XLAT_OK;
  end

  // fill side
  logic [IDX_W-1:0] fl_set;
  logic [TAG_W-1:0] fl_tag;
  logic             fl_hit, fl_hit_wok, fl_has_inv, fl_en;
  logic [WAY_W-1:0] fl_hit_way, fl_inv_way, fl_way, lru_victim;
  logic [PPN_W-1:0] fl_hit_ppn;

  assign fl_set = fill_vpn_i[IDX_W-1:0];
  assign fl_tag = fill_vpn_i[VPN_W-1:IDX_W];
  assign fl_en  = fill_valid_i && !flush_i;

  tlb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_fl_match (
    .tag_i (fl_tag),
    .val_i (val_q[fl_set]),
    .tags_i(tag_q[fl_set]),
    .ppns_i(ppn_q[fl_set]),
    .woks_i(wok_q[fl_set]),
    .hit_o (fl_hit),
    .way_o (fl_hit_way),
    .ppn_o (fl_hit_ppn),
    .wok_o (fl_hit_wok)
  );

  // lowest free way wins
  always_comb begin
    fl_has_inv = 1'b0;
    fl_inv_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!val_q[fl_set][w]) begin
        fl_has_inv = 1'b1;
        fl_inv_way = WAY_W'(w);
      end
    end
  end

  assign fl_way = fl_hit ? fl_hit_way : (fl_has_inv ? fl_inv_way : lru_victim);

  tlb_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lk_touch_i(req_valid_i && lk_hit),
    .lk_set_i  (lk_set),
    .lk_way_i  (lk_way),
    .fl_touch_i(fl_en),
    .fl_set_i  (fl_set),
    .fl_way_i  (fl_way),
    .victim_o  (lru_victim)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        val_q[s] <= '0;
        tag_q[s] <= '0;
        ppn_q[s] <= '0;
        wok_q[s] <= '0;
      end
    end else if (flush_i) begin
      for (int s = 0; s < SETS; s++) val_q[s] <= '0;
    end else if (fl_en) begin
      val_q[fl_set][fl_way] <= 1'b1;
      tag_q[fl_set][fl_way] <= fl_tag;
      ppn_q[fl_set][fl_way] <= fill_ppn_i;
      wok_q[fl_set][fl_way] <= fill_wr_ok_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_miss_o  <= 1'b0;
      rsp_wprot_o <= 1'b0;
      rsp_paddr_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_miss_o  <= req_valid_i && (lk_res == XLAT_MISS);
      rsp_wprot_o <= req_valid_i && (lk_res == XLAT_WPROT);
      rsp_paddr_o <= (req_valid_i && lk_res == XLAT_OK) ?
                     {lk_ppn, req_vaddr_i[OFS_W-1:0]} : '0;
    end
  end
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
  parameter int VA_W = 32,
  parameter int PA_W = 30,
  parameter int SETS = 16,
  parameter int WAYS = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_write_i,
  input logic [VA_W-1:0] req_vaddr_i,
  input logic            flush_i,
  input logic            rsp_valid_o,
  input logic            rsp_miss_o,
  input logic            rsp_wprot_o,
  input logic [PA_W-1:0] rsp_paddr_o,
  input logic [WAYS-1:0] val_q [SETS]
);
  localparam int OFS_W = tlb_pkg::PAGE_OFS_W;

  logic any_val;
  always_comb begin
    any_val = 1'b0;
    for (int s = 0; s < SETS; s++) any_val = any_val | (|val_q[s]);
  end

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  // R2
  idle_rsp_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && !rsp_miss_o && !rsp_wprot_o && rsp_paddr_o == '0));

  // R4
  single_outcome_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rsp_miss_o, rsp_wprot_o}));

  // R1
  offset_passthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (rsp_miss_o || rsp_wprot_o ||
                     rsp_paddr_o[OFS_W-1:0] == $past(req_vaddr_i[OFS_W-1:0])));

  // R4
  read_no_wprot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i) |=> !rsp_wprot_o);

  // R3
  miss_zero_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_miss_o |-> rsp_paddr_o == '0);

  // R9
  flush_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !any_val);
endmodule

bind page_xlat_tlb tlb_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .SETS(SETS), .WAYS(WAYS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_write_i(req_write_i),
  .req_vaddr_i(req_vaddr_i),
  .flush_i    (flush_i),
  .rsp_valid_o(rsp_valid_o),
  .rsp_miss_o (rsp_miss_o),
  .rsp_wprot_o(rsp_wprot_o),
  .rsp_paddr_o(rsp_paddr_o),
  .val_q      (val_q)
);

// File: tb/tb_page_xlat_tlb.sv
`timescale 1ns/100ps
module tb_page_xlat_tlb;
  localparam int VA_W = 32, PA_W = 30, OFS = 12;
  localparam int SETS = 16, WAYS = 4, IDX_W = 4;
  localparam int VPN_W = VA_W - OFS, PPN_W = PA_W - OFS, TAG_W = VPN_W - IDX_W;
  localparam int RW = PA_W + 2;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 0, req_write_i = 0, fill_valid_i = 0, fill_wr_ok_i = 0, flush_i = 0;
  logic [VA_W-1:0]  req_vaddr_i = '0;
  logic [VPN_W-1:0] fill_vpn_i = '0;
  logic [PPN_W-1:0] fill_ppn_i = '0;
  logic rsp_valid_o, rsp_miss_o, rsp_wprot_o;
  logic [PA_W-1:0] rsp_paddr_o;

  page_xlat_tlb dut (.*);

  always #2.5 clk_i = ~clk_i;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model: per set, position 0 = most recent
  int               m_cnt [SETS];
  logic [TAG_W-1:0] m_tag [SETS][WAYS];
  logic [PPN_W-1:0] m_ppn [SETS][WAYS];
  logic             m_wok [SETS][WAYS];

  logic [RW-1:0] exp_q [$];
  string         lbl_q [$];

  task automatic chk(string r, logic [RW-1:0] act, logic [RW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  function automatic int m_find(int s, logic [TAG_W-1:0] t);
    for (int i = 0; i < m_cnt[s]; i++) if (m_tag[s][i] == t) return i;
    return -1;
  endfunction

  function automatic void m_touch(int s, int p);
    logic [TAG_W-1:0] t = m_tag[s][p];
    logic [PPN_W-1:0] q = m_ppn[s][p];
    logic             k = m_wok[s][p];
    for (int i = p; i > 0; i--) begin
      m_tag[s][i] = m_tag[s][i-1];
      m_ppn[s][i] = m_ppn[s][i-1];
      m_wok[s][i] = m_wok[s][i-1];
    end
    m_tag[s][0] = t; m_ppn[s][0] = q; m_wok[s][0] = k;
  endfunction

  function automatic void m_fill(logic [VPN_W-1:0] vpn, logic [PPN_W-1:0] ppn, logic wok);
    int s = int'(vpn[IDX_W-1:0]);
    logic [TAG_W-1:0] t = vpn[VPN_W-1:IDX_W];
    int p = m_find(s, t);
    if (p < 0) begin
      if (m_cnt[s] < WAYS) begin p = m_cnt[s]; m_cnt[s]++; end
      else p = WAYS - 1;
      m_tag[s][p] = t;
    end
    m_ppn[s][p] = ppn;
    m_wok[s][p] = wok;
    m_touch(s, p);
  endfunction

  function automatic logic [RW-1:0] m_look(logic [VA_W-1:0] va, logic wr);
    int s = int'(va[OFS +: IDX_W]);
    int p = m_find(s, va[VA_W-1 -: TAG_W]);
    if (p < 0) return {1'b1, 1'b0, {PA_W{1'b0}}};
    m_touch(s, p);
    if (wr && !m_wok[s][0]) return {1'b0, 1'b1, {PA_W{1'b0}}};
    return {2'b00, m_ppn[s][0], va[OFS-1:0]};
  endfunction

  function automatic logic [VA_W-1:0] va_of(logic [TAG_W-1:0] t, logic [IDX_W-1:0] s, logic [OFS-1:0] o);
    return {t, s, o};
  endfunction

  function automatic logic [VPN_W-1:0] vpn_of(logic [TAG_W-1:0] t, logic [IDX_W-1:0] s);
    return {t, s};
  endfunction

  // driver: one cycle, starts and ends at a falling edge
  task automatic cyc(bit rq, bit wr, logic [VA_W-1:0] va, bit fv, logic [VPN_W-1:0] vpn,
                     logic [PPN_W-1:0] ppn, bit wok, bit fl, string r);
    if (rq) begin exp_q.push_back(m_look(va, wr)); lbl_q.push_back(r); end
    if (fl) begin for (int s = 0; s < SETS; s++) m_cnt[s] = 0; end
    else if (fv) m_fill(vpn, ppn, wok);
    req_valid_i = rq; req_write_i = wr; req_vaddr_i = va;
    fill_valid_i = fv; fill_vpn_i = vpn; fill_ppn_i = ppn; fill_wr_ok_i = wok; flush_i = fl;
    @(negedge clk_i);
    req_valid_i = 0; req_write_i = 0; fill_valid_i = 0; flush_i = 0;
  endtask

  task automatic look(logic [VA_W-1:0] va, bit wr, string r);
    cyc(1, wr, va, 0, '0, '0, 0, 0, r);
  endtask

  task automatic fill(logic [VPN_W-1:0] vpn, logic [PPN_W-1:0] ppn, bit wok, string r);
    cyc(0, 0, '0, 1, vpn, ppn, wok, 0, r);
  endtask

  // monitor / scoreboard
  bit lat_req;
  initial forever begin
    @(posedge clk_i);
    lat_req = req_valid_i && rst_ni;
    #1;
    if (rst_ni && !done) begin
      chk("R2 response valid timing", RW'(rsp_valid_o), RW'(lat_req));
      if (rsp_valid_o) begin
        if (exp_q.size() == 0) chk("R2 unexpected response", RW'(1), RW'(0));
        else chk(lbl_q.pop_front(), {rsp_miss_o, rsp_wprot_o, rsp_paddr_o}, exp_q.pop_front());
      end else begin
        chk("R2 idle outputs zero", {rsp_miss_o, rsp_wprot_o, rsp_paddr_o}, '0);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    for (int s = 0; s < SETS; s++) m_cnt[s] = 0;
    repeat (3) @(negedge clk_i);
    chk("R10 no response in reset", RW'(rsp_valid_o), '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R10 idle after reset", RW'(rsp_valid_o), '0);

    look(va_of(16'h0011, 4'd3, 12'h5A4), 0, "R10 empty after reset misses");
    look(va_of(16'h0011, 4'd3, 12'h5A4), 1, "R3 write miss");

    fill(vpn_of(16'h0011, 4'd3), 18'h2ABCD, 1, "fill");
    look(va_of(16'h0011, 4'd3, 12'h5A4), 0, "R1 read hit");
    look(va_of(16'h0011, 4'd3, 12'hFFF), 1, "R1 write hit permitted");
    look(va_of(16'h0011, 4'd4, 12'h000), 0, "R3 other set misses");

    fill(vpn_of(16'h0022, 4'd3), 18'h01234, 0, "fill");
    look(va_of(16'h0022, 4'd3, 12'h010), 1, "R4 write to read-only");
    look(va_of(16'h0022, 4'd3, 12'h010), 0, "R4 read of read-only");

    cyc(1, 0, va_of(16'h0033, 4'd3, 12'h0FF), 1, vpn_of(16'h0033, 4'd3), 18'h3FFFF, 1, 0,
        "R5 same-cycle lookup sees old contents");
    look(va_of(16'h0033, 4'd3, 12'h0FF), 0, "R5 fill visible next cycle");

    cyc(1, 0, va_of(16'h0011, 4'd3, 12'h001), 1, vpn_of(16'h0011, 4'd3), 18'h00777, 0, 0,
        "R5 lookup during overwrite sees old page");
    look(va_of(16'h0011, 4'd3, 12'h001), 1, "R6 overwrite changes permit");
    look(va_of(16'h0011, 4'd3, 12'h002), 0, "R6 overwrite changes page");
    fill(vpn_of(16'h0044, 4'd3), 18'h00044, 1, "fill");
    look(va_of(16'h0011, 4'd3, 12'h0), 0, "R6 no duplicate");
    look(va_of(16'h0022, 4'd3, 12'h0), 0, "R6 no duplicate");
    look(va_of(16'h0033, 4'd3, 12'h0), 0, "R6 no duplicate");
    look(va_of(16'h0044, 4'd3, 12'h0), 0, "R6 no duplicate");

    for (int t = 1; t <= 4; t++) fill(vpn_of(16'(16'h0100 + t), 4'd5), 18'(t * 3), 1, "fill");
    look(va_of(16'h0101, 4'd5, 12'h0), 0, "R8 hit refreshes");
    fill(vpn_of(16'h0105, 4'd5), 18'h00105, 1, "fill");
    look(va_of(16'h0102, 4'd5, 12'h0), 0, "R7 LRU victim evicted");
    look(va_of(16'h0101, 4'd5, 12'h0), 0, "R8 refreshed entry kept");
    look(va_of(16'h0103, 4'd5, 12'h0), 0, "R7 survivor");
    look(va_of(16'h0104, 4'd5, 12'h0), 0, "R7 survivor");
    look(va_of(16'h0105, 4'd5, 12'h0), 0, "R7 new entry");

    fill(vpn_of(16'h0201, 4'd6), 18'h00201, 0, "fill");
    for (int t = 2; t <= 4; t++) fill(vpn_of(16'(16'h0200 + t), 4'd6), 18'(t), 1, "fill");
    look(va_of(16'h0201, 4'd6, 12'h0), 1, "R8 write fault hit");
    fill(vpn_of(16'h0205, 4'd6), 18'h00205, 1, "fill");
    look(va_of(16'h0201, 4'd6, 12'h0), 0, "R8 fault hit refreshes");
    look(va_of(16'h0202, 4'd6, 12'h0), 0, "R8 LRU victim after fault hit");

    cyc(1, 0, va_of(16'h0101, 4'd5, 12'h123), 1, vpn_of(16'h0301, 4'd7), 18'h00301, 1, 1,
        "R9 lookup during flush sees old contents");
    look(va_of(16'h0101, 4'd5, 12'h0), 0, "R9 flushed");
    look(va_of(16'h0301, 4'd7, 12'h0), 0, "R9 fill in flush cycle dropped");
    look(va_of(16'h0044, 4'd3, 12'h0), 0, "R9 flushed");

    for (int s = 0; s < SETS; s++)
      for (int t = 0; t < WAYS; t++)
        fill(vpn_of(16'(16'h0400 + t), 4'(s)), 18'((s << 4) | t), 1, "fill");
    for (int s = 0; s < SETS; s++)
      for (int t = 0; t < WAYS; t++)
        look(va_of(16'(16'h0400 + t), 4'(s), 12'(s * 7 + t)), 0, "R7 full capacity");

    lf = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      logic [3:0] st;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      st = lf[3] ? 4'd9 : 4'd2;
      cyc(lf[5:4] != 2'd0, lf[6], va_of({13'h0, lf[2:0]}, st, lf[15:4]),
          lf[5:4] == 2'd0 || lf[5:4] == 2'd2, vpn_of({13'h0, lf[10:8]}, st),
          {lf, 2'b01}, lf[7], lf[15:10] == 6'd0, "R7 R8 mixed traffic");
    end

    repeat (3) @(negedge clk_i);
    chk("R2 every response seen", RW'(exp_q.size()), '0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule